// File: doc/BRIEF.md
# Configuration Block Checksum Checker

This block checks the integrity of a fixed-length block of 16-bit configuration words as they stream past. Each word arrives on a valid/ready handshake. The block length in words is a parameter. The final word of each block is the stored checksum, and every word before it contributes to a running sum.

The running sum is held in a 32-bit accumulator, so carries out of the low 16 bits are kept and not dropped. When the checksum word arrives, the low 16 bits of the sum are compared with it. The block passes only if they match and the whole 32-bit sum is not zero. A block of all-zero words is therefore rejected, which catches an erased or absent store.

A start pulse clears the accumulator and the word counter and opens the input. After the checksum word is accepted, the block reports its verdict with a one-cycle done pulse. The input then stays closed until the next start pulse.

Top module: `cfg_cksum_checker`

## Requirements
- R1: While reset is asserted, and after it is released with no start pulse, inReady, done and pass are all low.
- R2: In the cycle after a start pulse, inReady is high.
- R3: The words accepted before the last one of a block of NUM_WORDS words (default 8) are summed, and the last accepted word is the stored checksum; if the low 16 bits of the sum equal it and the sum is nonzero, pass is high together with done.
- R4: The accumulator is 32 bits wide; a block whose data words sum past 0xFFFF passes when the low 16 bits of the sum match, including a sum of 0x10000 with a checksum word of 0x0000.
- R5: If the low 16 bits of the sum differ from the checksum word, done pulses with pass low.
- R6: If the full 32-bit sum is zero, done pulses with pass low even when the checksum word is 0x0000.
- R7: done is high for exactly one cycle, in the cycle after the checksum word is accepted, and pass is never high without done.
- R8: From the done cycle until the next start pulse, inReady is low, and words offered with inValid high are ignored: no done pulse follows them.
- R9: A start pulse in the middle of a block discards the partial sum and word count, and the word offered in the same cycle as start is not accepted.
- R10: A word counts only in a cycle where inValid and inReady are both high; cycles with inValid low leave the sum and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears the state and opens the input |
| inValid | input | 1 | Word on inData is offered |
| inData | input | 16 | Configuration word or, last in the block, checksum word |
| inReady | output | 1 | Checker accepts a word this cycle |
| done | output | 1 | One-cycle pulse carrying the verdict |
| pass | output | 1 | Verdict, high only with done when the block is good |

## Verification
inReady rises one cycle after a start pulse. A word offered with inReady high is taken at the next rising edge. The verdict appears on done and pass in the cycle directly after the checksum word is taken, and inReady falls in that same cycle. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge. It then compares inReady, done and pass against the model at every falling edge, so each output is checked in the cycle it is due. Directed scenarios add named checks of the verdict and of the one-cycle width of done.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  typedef struct packed {
    logic clear;       // restart: zero the accumulator
    logic accumulate;  // add the accepted data word
    logic compare;     // accepted word is the stored checksum
  } ctrlStrobe_t;
endpackage

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import cksum_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inValid,
  output logic        inReady,
  output logic        done,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REPORT} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] wordCnt;
  logic accept;
  logic lastWord;

  assign inReady  = (state == ST_RUN);
  assign done     = (state == ST_REPORT);
  assign accept   = inValid && inReady && !start;
  assign lastWord = (wordCnt == LAST_IDX);

  always_comb begin
    strobe            = '0;
    strobe.clear      = start;
    strobe.accumulate = accept && !lastWord;
    strobe.compare    = accept && lastWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else if (start) begin
      state   <= ST_RUN;
      wordCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (accept) begin
            if (lastWord) begin
              state   <= ST_REPORT;
              wordCnt <= '0;
            end else begin
              wordCnt <= wordCnt + 1'b1;
            end
          end
        end
        ST_REPORT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> inReady); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.compare |=> done); // R7
  AST_CLOSED_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady); // R8
  AST_CLOSED_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !inReady); // R8
  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !start && inReady) |=> $stable(wordCnt)); // R10
endmodule

// File: rtl/cksum_datapath.sv
module cksum_datapath
  import cksum_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] word,
  output logic              pass
);
  logic [SUM_W-1:0] sumAcc;
  logic             verdict;

  assign verdict = (sumAcc[WORD_W-1:0] == word) && (sumAcc != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumAcc <= '0;
      pass   <= 1'b0;
    end else begin
      pass <= strobe.compare && verdict;
      if (strobe.clear)           sumAcc <= '0;
      else if (strobe.accumulate) sumAcc <= sumAcc + SUM_W'(word);
    end
  end

  AST_CLEAR_ZEROES_SUM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (sumAcc == '0)); // R9
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.accumulate) |=> $stable(sumAcc)); // R10
  AST_ZERO_SUM_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && sumAcc == '0) |=> !pass); // R6
  AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && sumAcc[WORD_W-1:0] != word) |=> !pass); // R5
endmodule

// File: rtl/cfg_cksum_checker.sv
module cfg_cksum_checker
  import cksum_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 16,
  parameter int SUM_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              done,
  output logic              pass
);
  ctrlStrobe_t strobe;

  cksum_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inReady(inReady), .done(done), .strobe(strobe)
  );

  cksum_datapath #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .word(inData), .pass(pass)
  );

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> (!inReady && !done && !pass)); // R1
endmodule

// File: tb/cfg_cksum_checker_tb.sv
module cfg_cksum_checker_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inData = '0;
  logic inReady, done, pass;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  bit  mRun = 0;
  int  mCnt = 0;
  longint mSum = 0;
  bit  expDone = 0;
  bit  expPass = 0;

  always #2.5 clk = ~clk;

  cfg_cksum_checker #(.NUM_WORDS(N)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inData(inData), .inReady(inReady), .done(done), .pass(pass)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mRun = 0; mCnt = 0; mSum = 0; expDone = 0; expPass = 0;
    end else begin
      expDone = 0; expPass = 0;
      if (start) begin
        mRun = 1; mCnt = 0; mSum = 0;
      end else if (mRun && inValid) begin
        if (mCnt == N - 1) begin
          expDone = 1;
          expPass = ((mSum & 64'hFFFF) == longint'(inData)) && (mSum != 0);
          mRun = 0; mCnt = 0;
        end else begin
          mSum = (mSum + longint'(inData)) & 64'hFFFF_FFFF;
          mCnt++;
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && cycles > 0) begin
      check(inReady == mRun, "R2/R8 inReady", int'(inReady), int'(mRun));
      check(done == expDone, "R7 done", int'(done), int'(expDone));
      check(pass == expPass, "R3 pass", int'(pass), int'(expPass));
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic startBlock();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    inValid = 1'b1;
    inData  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runBlock(input logic [15:0] w[N], input int gap,
                          input bit wantPass, input string tag);
    startBlock();
    check(inReady == 1'b1, "R2 ready after start", int'(inReady), 1);
    for (int i = 0; i < N; i++) begin
      sendWord(w[i]);
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    if (gap == 0) begin
      check(done == 1'b1, {tag, " done"}, int'(done), 1);
      check(pass == wantPass, {tag, " pass"}, int'(pass), int'(wantPass));
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done width", int'(done), 0);
  endtask

  initial begin
    logic [15:0] blk[N];
    @(negedge clk);
    check(inReady == 0 && done == 0 && pass == 0, "R1 in reset",
          int'({inReady, done, pass}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(inReady == 0 && done == 0 && pass == 0, "R1 after reset",
          int'({inReady, done, pass}), 0);

    // R3: 1..7 sum to 28
    for (int i = 0; i < N - 1; i++) blk[i] = 16'(i + 1);
    blk[N-1] = 16'd28;
    runBlock(blk, 0, 1'b1, "R3");

    // R5: checksum off by one
    blk[N-1] = 16'd27;
    runBlock(blk, 0, 1'b0, "R5");

    // R6: all zero, checksum zero
    for (int i = 0; i < N; i++) blk[i] = 16'h0000;
    runBlock(blk, 0, 1'b0, "R6");

    // R4: carries kept, sum 0x6FFF9
    for (int i = 0; i < N - 1; i++) blk[i] = 16'hFFFF;
    blk[N-1] = 16'hFFF9;
    runBlock(blk, 0, 1'b1, "R4 wide sum");

    // R4: sum 0x10000 with checksum zero passes
    for (int i = 0; i < N; i++) blk[i] = 16'h0000;
    blk[0] = 16'h8000; blk[1] = 16'h8000;
    runBlock(blk, 0, 1'b1, "R4 low zero");

    // R10: gaps with inValid low between words
    for (int i = 0; i < N - 1; i++) blk[i] = 16'(100 * i + 3);
    blk[N-1] = 16'd2121;
    runBlock(blk, 2, 1'b1, "R10");

    // R9: restart mid-block; word offered with start is dropped
    startBlock();
    sendWord(16'h1234);
    sendWord(16'h4321);
    inValid = 1'b1; inData = 16'h7777;
    for (int i = 0; i < N - 1; i++) blk[i] = 16'(i + 1);
    blk[N-1] = 16'd28;
    runBlock(blk, 0, 1'b1, "R9");
    inValid = 1'b0;

    // R8: words offered after done are ignored
    inValid = 1'b1; inData = 16'h0001;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(inReady == 0 && done == 0, "R8 closed",
            int'({inReady, done}), 0);
    end
    inValid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule